// File: doc/BRIEF.md
# Scaled Index Address Accumulator

This block forms an effective address over several clock cycles. Each accepted step does one of two things. It loads a general register into an accumulator, or it adds a general register to the accumulator after shifting that register left by 0, 1, 2 or 3 bit positions. A sequence such as "load base, add index scaled by 8" leaves the base-plus-scaled-index address in the accumulator. The register contents arrive on a combinational read port: the block drives the register index out and the register file returns the data in the same cycle.

Every step comes in a narrow form and a wide form. A narrow form computes its result and then keeps only the low 32 bits, clearing the upper half. A wide form keeps all 64 bits and wraps modulo 2^64. The wide forms are legal only while the wide-mode input is high. A wide form issued with wide mode low is rejected: the accumulator keeps its value and an illegal-operation flag pulses for one cycle. A completed step raises a done pulse in the cycle its result becomes visible.

Top module: `addr_accum`

## Requirements
- R1: A narrow load (op_code_i = 2'b00) sets acc_o to the selected register with bits 63:32 cleared, in either mode.
- R2: A narrow add (op_code_i = 2'b01) sets acc_o to ((acc_o + (reg << scale_i)) mod 2^32), zero-extended, in either mode. scale_i gives the shift amount 0 to 3 directly.
- R3: A wide add (op_code_i = 2'b11) in wide mode sets acc_o to (acc_o + (reg << scale_i)) mod 2^64.
- R4: A wide load (op_code_i = 2'b10) in wide mode copies all 64 register bits into acc_o.
- R5: A wide form (op_code_i[1] = 1) issued with wide_mode_i low leaves acc_o unchanged, raises illegal_o for exactly the next cycle, and does not raise done_o.
- R6: Each accepted legal step updates acc_o and raises done_o one cycle after the clock edge that samples op_valid_i.
- R7: scale_i has no effect on load steps.
- R8: While op_valid_i is low, acc_o holds its value and done_o and illegal_o stay low.
- R9: rst_ni low clears acc_o, done_o and illegal_o at once, without waiting for a clock edge.
- R10: rd_idx_o follows reg_idx_i combinationally, so rd_data_i is used in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A step is presented this cycle |
| op_code_i | input | 2 | bit0: 1 = add, 0 = load; bit1: 1 = wide form |
| reg_idx_i | input | 4 | General register selected for the step |
| scale_i | input | 2 | Left shift applied to the register on an add |
| wide_mode_i | input | 1 | Enables the wide forms |
| rd_idx_o | output | 4 | Register file read index |
| rd_data_i | input | 64 | Register file read data |
| acc_o | output | 64 | Accumulated address |
| done_o | output | 1 | One-cycle pulse after a completed step |
| illegal_o | output | 1 | One-cycle pulse after a rejected step |

## Verification
The accumulator is the only state, so any wrong value in it shows on acc_o one cycle after the step that corrupts it. It also spreads into every later add until the next load overwrites it. A bad truncation shows up as nonzero upper bits after a narrow step. A wrong scale mux only shows when the shifted index carries into a different bit pattern, so the checks pair large register values with every scale. A decode error on the wide forms shows in the next cycle as a wrong pulse on done_o or illegal_o, or as an accumulator that moved when it should have held.

// File: rtl/addr_accum_pkg.sv
package addr_accum_pkg;

  typedef enum logic [1:0] {
    OP_LD_N  = 2'b00,
    OP_ADD_N = 2'b01,
    OP_LD_W  = 2'b10,
    OP_ADD_W = 2'b11
  } op_e;

  typedef struct packed {
    logic take;    // legal step, update accumulator
    logic reject;  // wide form outside wide mode
    logic is_add;
    logic narrow;
  } step_ctrl_t;

endpackage

// File: rtl/addr_step_decode.sv
module addr_step_decode
  import addr_accum_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic       wide_mode_i,
  output step_ctrl_t ctrl_o
);

  op_e  op;
  logic wide_form;

  always_comb begin
    op        = op_e'(op_i);
    wide_form = (op == OP_LD_W) || (op == OP_ADD_W);
    ctrl_o.is_add = (op == OP_ADD_N) || (op == OP_ADD_W);
    ctrl_o.narrow = !wide_form;
    ctrl_o.reject = valid_i && wide_form && !wide_mode_i;
    ctrl_o.take   = valid_i && !(wide_form && !wide_mode_i);
  end

endmodule

// File: rtl/addr_scale_add.sv
module addr_scale_add #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NARROW  = 32,
  parameter int unsigned SCALE_W = 2
) (
  input  logic [XLEN-1:0]    acc_i,
  input  logic [XLEN-1:0]    reg_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               is_add_i,
  input  logic               narrow_i,
  output logic [XLEN-1:0]    next_o
);

  localparam int unsigned NSCALE = 1 << SCALE_W;

  logic [NSCALE-1:0][XLEN-1:0] cand;
  logic [XLEN-1:0]             scaled;
  logic [XLEN-1:0]             raw;
  logic [XLEN-1:0]             trunc;

  for (genvar s = 0; s < NSCALE; s++) begin : g_shift
    assign cand[s] = reg_i << s;
  end

  assign scaled = cand[scale_i];
  assign raw    = is_add_i ? (acc_i + scaled) : reg_i;

  if (NARROW < XLEN) begin : g_trunc
    assign trunc = {{(XLEN-NARROW){1'b0}}, raw[NARROW-1:0]};
  end else begin : g_full
    assign trunc = raw;
  end

  assign next_o = narrow_i ? trunc : raw;

endmodule

// File: rtl/addr_accum_state.sv
module addr_accum_state #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            reject_i,
  input  logic [XLEN-1:0] next_i,
  output logic [XLEN-1:0] acc_o,
  output logic            done_o,
  output logic            illegal_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o     <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      if (take_i) acc_o <= next_i;
      done_o    <= take_i;
      illegal_o <= reject_i;
    end
  end

endmodule

// File: rtl/addr_accum.sv
module addr_accum
  import addr_accum_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NARROW  = 32,
  parameter int unsigned NREG    = 16,
  parameter int unsigned SCALE_W = 2,
  localparam int unsigned IDX_W  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [1:0]         op_code_i,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               wide_mode_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  input  logic [XLEN-1:0]    rd_data_i,
  output logic [XLEN-1:0]    acc_o,
  output logic               done_o,
  output logic               illegal_o
);

  step_ctrl_t      ctrl;
  logic [XLEN-1:0] next_acc;

  assign rd_idx_o = reg_idx_i;

  addr_step_decode u_dec (
    .valid_i     (op_valid_i),
    .op_i        (op_code_i),
    .wide_mode_i (wide_mode_i),
    .ctrl_o      (ctrl)
  );

  addr_scale_add #(
    .XLEN    (XLEN),
    .NARROW  (NARROW),
    .SCALE_W (SCALE_W)
  ) u_dp (
    .acc_i    (acc_o),
    .reg_i    (rd_data_i),
    .scale_i  (scale_i),
    .is_add_i (ctrl.is_add),
    .narrow_i (ctrl.narrow),
    .next_o   (next_acc)
  );

  addr_accum_state #(.XLEN(XLEN)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (ctrl.take),
    .reject_i  (ctrl.reject),
    .next_i    (next_acc),
    .acc_o     (acc_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

endmodule

// File: rtl/addr_accum_chk.sv
module addr_accum_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NARROW  = 32,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned SCALE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_valid_i,
  input logic [1:0]         op_code_i,
  input logic [IDX_W-1:0]   reg_idx_i,
  input logic [SCALE_W-1:0] scale_i,
  input logic               wide_mode_i,
  input logic [IDX_W-1:0]   rd_idx_o,
  input logic [XLEN-1:0]    rd_data_i,
  input logic [XLEN-1:0]    acc_o,
  input logic               done_o,
  input logic               illegal_o
);

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !op_code_i[1] |=> acc_o[XLEN-1:NARROW] == '0); // R1

  AST_WIDE_LOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_code_i == 2'b10 && wide_mode_i |=> acc_o == $past(rd_data_i)); // R4

  AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_code_i[1] && !wide_mode_i |=> illegal_o && !done_o && $stable(acc_o)); // R5

  AST_DONE_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !(op_code_i[1] && !wide_mode_i) |=> done_o && !illegal_o); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !done_o && !illegal_o && $stable(acc_o)); // R8

  AST_READ_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_o == reg_idx_i); // R10

endmodule

bind addr_accum addr_accum_chk #(
  .XLEN    (XLEN),
  .NARROW  (NARROW),
  .IDX_W   (IDX_W),
  .SCALE_W (SCALE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_code_i   (op_code_i),
  .reg_idx_i   (reg_idx_i),
  .scale_i     (scale_i),
  .wide_mode_i (wide_mode_i),
  .rd_idx_o    (rd_idx_o),
  .rd_data_i   (rd_data_i),
  .acc_o       (acc_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o)
);

// File: tb/addr_accum_test.sv
`timescale 1ns/1ps
module addr_accum_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic [3:0]  reg_idx = '0;
  logic [1:0]  scale = '0;
  logic        wide = 1'b0;
  logic [3:0]  rd_idx;
  logic [63:0] rd_data;
  logic [63:0] acc;
  logic        done, illegal;

  logic [63:0] rf [16];
  logic [63:0] acc_m = '0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign rd_data = rf[rd_idx];

  addr_accum uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .op_code_i(op_code),
    .reg_idx_i(reg_idx), .scale_i(scale), .wide_mode_i(wide), .rd_idx_o(rd_idx),
    .rd_data_i(rd_data), .acc_o(acc), .done_o(done), .illegal_o(illegal)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [1:0] c,
                                        input logic [63:0] r, input logic [1:0] s);
    logic [63:0] t;
    t = c[0] ? a + (r << s) : r;
    if (!c[1]) t = {32'h0, t[31:0]};
    return t;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [3:0] i, input logic [1:0] s,
                      input logic w, input string tag);
    bit bad;
    op_valid = 1'b1; op_code = c; reg_idx = i; scale = s; wide = w;
    #1;
    chk(rd_idx == i, "R10 read index", 64'(rd_idx), 64'(i));
    bad = c[1] && !w;
    if (!bad) acc_m = model(acc_m, c, rf[i], s);
    @(negedge clk);
    chk(acc == acc_m, tag, acc, acc_m);
    chk(done == !bad, bad ? "R5 no done" : "R6 done", 64'(done), 64'(!bad));
    chk(illegal == bad, bad ? "R5 illegal" : "R6 no illegal", 64'(illegal), 64'(bad));
  endtask

  task automatic idle(input int n);
    op_valid = 1'b0;
    op_code = 2'(n); scale = 2'(n); reg_idx = 4'(n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(acc == acc_m, "R8 hold", acc, acc_m);
      chk(!done && !illegal, "R8 quiet", {62'h0, done, illegal}, 64'h0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 16; k++) rf[k] = {$urandom, $urandom};
    rf[1] = 64'hFFFF_FFFF_8000_0001;
    rf[2] = 64'h0000_0000_FFFF_FFF0;
    rf[3] = 64'h0000_0000_0000_0009;
    rf[4] = 64'hFFFF_FFFF_FFFF_FFF0;
    rf[5] = 64'h0000_0000_0000_0004;
    rf[6] = 64'hA5A5_5A5A_1234_8765;

    repeat (3) @(negedge clk);
    chk(acc == 0 && !done && !illegal, "R9 reset state", acc, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    step(2'b00, 4'd1, 2'd0, 1'b0, "R1 narrow load");
    chk(acc == 64'h8000_0001, "R1 narrow load value", acc, 64'h8000_0001);
    step(2'b00, 4'd6, 2'd0, 1'b1, "R1 narrow load wide mode");
    step(2'b00, 4'd2, 2'd0, 1'b0, "R1 load base");
    step(2'b01, 4'd3, 2'd1, 1'b0, "R2 narrow add wrap");
    chk(acc == 64'h2, "R2 wrap value", acc, 64'h2);
    for (int s = 0; s < 4; s++) step(2'b01, 4'd6, 2'(s), 1'b1, "R2 narrow add scale");
    step(2'b10, 4'd4, 2'd0, 1'b1, "R4 wide load");
    chk(acc == 64'hFFFF_FFFF_FFFF_FFF0, "R4 full value", acc, 64'hFFFF_FFFF_FFFF_FFF0);
    step(2'b11, 4'd5, 2'd3, 1'b1, "R3 wide add wrap");
    chk(acc == 64'h10, "R3 wrap value", acc, 64'h10);
    for (int s = 0; s < 4; s++) step(2'b11, 4'd6, 2'(s), 1'b1, "R3 wide add scale");
    step(2'b10, 4'd6, 2'd3, 1'b1, "R7 wide load scale ignored");
    chk(acc == rf[6], "R7 load value", acc, rf[6]);
    step(2'b00, 4'd6, 2'd2, 1'b0, "R7 narrow load scale ignored");
    step(2'b10, 4'd4, 2'd0, 1'b0, "R5 wide load rejected");
    step(2'b11, 4'd4, 2'd1, 1'b0, "R5 wide add rejected");
    idle(1);
    chk(!illegal, "R5 single pulse", 64'(illegal), 64'h0);
    idle(3);

    for (int n = 0; n < 400; n++) begin
      if (n % 37 == 0) rf[$urandom % 16] = {$urandom, $urandom};
      if ($urandom % 8 == 0) idle(1);
      else step(2'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), "R6 random step");
    end

    step(2'b10, 4'd6, 2'd0, 1'b1, "R4 load before reset");
    op_valid = 1'b0;
    #2 rst_ni = 1'b0;
    #1;
    chk(acc == 0 && !done, "R9 async clear", acc, 64'h0);
    acc_m = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule